// File: doc/BRIEF.md
# Byte-Wide Data Space with Pointer Redirection

This block is the 128-location, 8-bit data address space of a small microcontroller core. One port serves it: a 7-bit address, a write enable, write data and a read-data output. Reads are combinational from the address. Writes are committed on the rising clock edge. The space holds three kinds of location:

- a 64-byte general-purpose RAM in the upper half;
- a small set of core registers in the lower half: a 7-bit pointer, an accumulator and a bank of placeholder peripheral registers;
- reserved holes, which read as zero.

Address 00H has no storage behind it. Any access there is steered to the location whose address is held in the pointer. This lets the core walk through memory with a single register. When the pointer itself holds 00H, the steered access lands nowhere: a read gives zero and a write is dropped. The core also sees the pointer and the accumulator directly on dedicated outputs.

Top module: `dmem_space`

## Requirements
- R1: Addresses 40H to 7FH are 64 bytes of general-purpose storage; a byte written to one of them reads back unchanged at that address, and other bytes of the region are unaffected.
- R2: Address 01H is the pointer; a write there stores only data bits 6:0, and `ptr_o` shows the stored 7-bit value from the edge after the write.
- R3: A read of address 01H returns bit 7 as 1 and bits 6:0 as the pointer.
- R4: A read or write at address 00H acts on the address held in the pointer, with the same effect as a direct access to that address; this includes a pointer value of 01H, where the write replaces the pointer.
- R5: With the pointer at 00H, a read at 00H returns 00H, and a write at 00H changes no location.
- R6: Every address below 40H other than 01H, 05H and the placeholder bank (10H to 17H by default) is reserved: it reads as 00H and writes to it are dropped.
- R7: Address 05H is the accumulator; it reads and writes like memory, and `acc_o` shows its value.
- R8: A synchronous active-high reset clears the pointer, the accumulator and the placeholder registers; RAM contents are not reset.
- R9: `rdata` follows `addr` in the same cycle; a write changes what is read only after the rising edge that commits it, so in the write cycle itself the old value is seen.
- R10: The placeholder bank, at PH_BASE to PH_BASE+PH_COUNT-1, holds plain read/write bytes.
- R11: With `wr_en` low, no location changes, whatever `addr` and `wdata` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Address of the access (00H means through the pointer) |
| wr_en | input | 1 | Write enable for the current cycle |
| wdata | input | 8 | Data to write |
| rdata | output | 8 | Combinational read data for `addr` |
| ptr_o | output | 7 | Current pointer value |
| acc_o | output | 8 | Current accumulator value |

## Verification
Redirection and a pointer update can fall in the same cycle. This happens when a write at 00H is made while the pointer holds 01H: the pointer is then both the thing steering the access and the thing being written. The bench provokes this case and judges three things.

- In the write cycle, the read at 00H still shows the old pointer.
- After the edge, `ptr_o` carries the masked new value.
- A following read at 00H reaches the RAM byte named by the new pointer.

A second case writes at 00H while the pointer is 00H. The bench then confirms that the pointer, the accumulator and a chosen RAM byte are all unchanged.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int GP_AW    = ADDR_W - 1;
    localparam int GP_DEPTH = 1 << GP_AW;

    localparam logic [ADDR_W-1:0] A_INDIRECT = 7'h00;
    localparam logic [ADDR_W-1:0] A_POINTER  = 7'h01;
    localparam logic [ADDR_W-1:0] A_ACCUM    = 7'h05;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        LOC_VOID,
        LOC_PTR,
        LOC_ACC,
        LOC_PH,
        LOC_GP
    } loc_kind_e;

    typedef struct packed {
        loc_kind_e kind;
        addr_t     eff;
    } route_t;

    function automatic logic in_gp(input addr_t a);
        return a[ADDR_W-1];
    endfunction

    function automatic byte_t ptr_view(input addr_t p);
        return {1'b1, p};
    endfunction

endpackage

// File: rtl/dmem_route.sv
module dmem_route
    import dmem_pkg::*;
#(
    parameter int PH_BASE  = 16,
    parameter int PH_COUNT = 8
) (
    input  addr_t  addr,
    input  addr_t  ptr,
    output route_t route
);
    localparam int PH_LAST = PH_BASE + PH_COUNT - 1;

    always_comb begin
        route.eff  = (addr == A_INDIRECT) ? ptr : addr;
        route.kind = LOC_VOID;
        if (in_gp(route.eff))
            route.kind = LOC_GP;
        else if (route.eff == A_POINTER)
            route.kind = LOC_PTR;
        else if (route.eff == A_ACCUM)
            route.kind = LOC_ACC;
        else if (int'(route.eff) >= PH_BASE && int'(route.eff) <= PH_LAST)
            route.kind = LOC_PH;
    end

endmodule

// File: rtl/dmem_gpr.sv
module dmem_gpr
    import dmem_pkg::*;
(
    input  logic             clk,
    input  logic             we,
    input  logic [GP_AW-1:0] idx,
    input  byte_t            wdata,
    output byte_t            rdata
);
    byte_t mem [GP_DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/dmem_core_regs.sv
module dmem_core_regs
    import dmem_pkg::*;
#(
    parameter int PH_BASE  = 16,
    parameter int PH_COUNT = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  route_t route,
    input  byte_t  wdata,
    output byte_t  rdata,
    output addr_t  ptr_q,
    output byte_t  acc_q
);
    byte_t ph_q [PH_COUNT];
    byte_t ph_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            acc_q <= '0;
        end else if (wr_en) begin
            if (route.kind == LOC_PTR)
                ptr_q <= wdata[ADDR_W-1:0];
            if (route.kind == LOC_ACC)
                acc_q <= wdata;
        end
    end

    for (genvar g = 0; g < PH_COUNT; g++) begin : g_ph
        always_ff @(posedge clk) begin
            if (rst)
                ph_q[g] <= '0;
            else if (wr_en && route.kind == LOC_PH && int'(route.eff) == PH_BASE + g)
                ph_q[g] <= wdata;
        end
    end

    always_comb begin
        ph_rd = '0;
        for (int i = 0; i < PH_COUNT; i++)
            if (int'(route.eff) == PH_BASE + i)
                ph_rd = ph_q[i];
    end

    always_comb begin
        unique case (route.kind)
            LOC_PTR: rdata = ptr_view(ptr_q);
            LOC_ACC: rdata = acc_q;
            LOC_PH:  rdata = ph_rd;
            default: rdata = '0;
        endcase
    end

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> (ptr_q == '0 && acc_q == '0));

    assert_ptr_masked_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && route.kind == LOC_PTR) |=> ptr_q == $past(wdata[ADDR_W-1:0]));

    assert_hold_without_write_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(ptr_q) && $stable(acc_q)));

endmodule

// File: rtl/dmem_space.sv
module dmem_space
    import dmem_pkg::*;
#(
    parameter int PH_BASE  = 16,
    parameter int PH_COUNT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   ptr_o,
    output logic [DATA_W-1:0]   acc_o
);
    route_t route;
    addr_t  ptr_q;
    byte_t  acc_q;
    byte_t  gp_rd;
    byte_t  reg_rd;

    dmem_route #(.PH_BASE(PH_BASE), .PH_COUNT(PH_COUNT)) u_route (
        .addr  (addr),
        .ptr   (ptr_q),
        .route (route)
    );

    dmem_gpr u_gpr (
        .clk   (clk),
        .we    (wr_en && route.kind == LOC_GP),
        .idx   (route.eff[GP_AW-1:0]),
        .wdata (wdata),
        .rdata (gp_rd)
    );

    dmem_core_regs #(.PH_BASE(PH_BASE), .PH_COUNT(PH_COUNT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .route (route),
        .wdata (wdata),
        .rdata (reg_rd),
        .ptr_q (ptr_q),
        .acc_q (acc_q)
    );

    assign rdata = (route.kind == LOC_GP) ? gp_rd : reg_rd;
    assign ptr_o = ptr_q;
    assign acc_o = acc_q;

    assert_ptr_bit7_R3: assert property (@(posedge clk) disable iff (rst)
        (addr == A_POINTER) |-> (rdata[DATA_W-1] == 1'b1 && rdata[ADDR_W-1:0] == ptr_o));

    assert_null_ptr_read_R5: assert property (@(posedge clk) disable iff (rst)
        (addr == A_INDIRECT && ptr_o == '0) |-> rdata == '0);

    assert_null_ptr_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_INDIRECT && ptr_o == '0) |=> ($stable(ptr_o) && $stable(acc_o)));

    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (addr != A_INDIRECT && addr < 7'h40 && addr != A_POINTER && addr != A_ACCUM &&
         (int'(addr) < PH_BASE || int'(addr) >= PH_BASE + PH_COUNT)) |-> rdata == '0);

endmodule

// File: tb/test_dmem_space.sv
module test_dmem_space;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [6:0] ptr_o;
    logic [7:0] acc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    dmem_space i_dmem_space (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .ptr_o(ptr_o), .acc_o(acc_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        #1 check(req, rdata, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd(7'h01, 8'h80, "R8 ptr read");
        rd(7'h05, 8'h00, "R8 acc read");
        rd(7'h10, 8'h00, "R8 placeholder");
        check("R8 ptr_o", {1'b0, ptr_o}, 8'h00);
        check("R8 acc_o", acc_o, 8'h00);
    endtask

    task automatic t_gp;
        wr(7'h40, 8'h11);
        wr(7'h7F, 8'hEE);
        wr(7'h55, 8'h5A);
        rd(7'h40, 8'h11, "R1 low end");
        rd(7'h7F, 8'hEE, "R1 high end");
        rd(7'h55, 8'h5A, "R1 middle");
    endtask

    task automatic t_ptr;
        wr(7'h01, 8'hC3);
        check("R2 masked ptr_o", {1'b0, ptr_o}, 8'h43);
        rd(7'h01, 8'hC3, "R3 bit7 set");
        wr(7'h01, 8'h2A);
        rd(7'h01, 8'hAA, "R3 bit7 set after 0 written");
    endtask

    task automatic t_acc;
        wr(7'h05, 8'h9C);
        rd(7'h05, 8'h9C, "R7 acc read");
        check("R7 acc_o", acc_o, 8'h9C);
    endtask

    task automatic t_indirect;
        wr(7'h01, 8'h55);
        rd(7'h00, 8'h5A, "R4 indirect read RAM");
        wr(7'h00, 8'h77);
        rd(7'h55, 8'h77, "R4 indirect write RAM");
        wr(7'h01, 8'h05);
        rd(7'h00, 8'h9C, "R4 indirect read acc");
        wr(7'h00, 8'h3D);
        check("R4 indirect write acc", acc_o, 8'h3D);
    endtask

    task automatic t_self_ptr;
        wr(7'h01, 8'h01);
        @(negedge clk);
        addr = 7'h00; wdata = 8'hC0; wr_en = 1'b1;
        #1 check("R4 old ptr seen in write cycle", rdata, 8'h81);
        @(negedge clk);
        wr_en = 1'b0;
        check("R4 ptr replaced via indirect", {1'b0, ptr_o}, 8'h40);
        rd(7'h00, 8'h11, "R4 follows new ptr");
    endtask

    task automatic t_null_ptr;
        wr(7'h01, 8'h80);
        check("R5 ptr zero", {1'b0, ptr_o}, 8'h00);
        rd(7'h00, 8'h00, "R5 null read");
        wr(7'h00, 8'hF1);
        rd(7'h01, 8'h80, "R5 ptr unchanged");
        check("R5 acc unchanged", acc_o, 8'h3D);
        rd(7'h40, 8'h11, "R5 RAM unchanged");
    endtask

    task automatic t_reserved;
        wr(7'h02, 8'hFF);
        rd(7'h02, 8'h00, "R6 reserved 02");
        wr(7'h3F, 8'h12);
        rd(7'h3F, 8'h00, "R6 reserved 3F");
        rd(7'h18, 8'h00, "R6 after bank");
        check("R6 acc untouched", acc_o, 8'h3D);
    endtask

    task automatic t_placeholder;
        wr(7'h10, 8'hA5);
        wr(7'h17, 8'h5A);
        rd(7'h10, 8'hA5, "R10 first");
        rd(7'h17, 8'h5A, "R10 last");
    endtask

    task automatic t_timing;
        @(negedge clk);
        addr = 7'h66; wdata = 8'h01; wr_en = 1'b1;
        @(negedge clk);
        addr = 7'h66; wdata = 8'hB7; wr_en = 1'b1;
        #1 check("R9 old value in write cycle", rdata, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R9 new value after edge", rdata, 8'hB7);
    endtask

    task automatic t_no_write;
        @(negedge clk);
        addr = 7'h66; wdata = 8'h00; wr_en = 1'b0;
        @(negedge clk);
        addr = 7'h05; wdata = 8'hEE;
        @(negedge clk);
        rd(7'h66, 8'hB7, "R11 RAM held");
        check("R11 acc held", acc_o, 8'h3D);
    endtask

    task automatic t_reset_ram;
        t_reset;
        rd(7'h40, 8'h11, "R8 RAM not reset");
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_gp;
                t_ptr;
                t_acc;
                t_indirect;
                t_self_ptr;
                t_null_ptr;
                t_reserved;
                t_placeholder;
                t_timing;
                t_no_write;
                t_reset_ram;
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule